// File: doc/BRIEF.md
# Counter Overflow Interrupt Controller

This block gathers the overflow pulses of a bank of event counters into one interrupt line. There are twenty-four sources in a single 24-bit field. The upper sixteen bits belong to the general-purpose counters. The lower eight bits belong to the bandwidth counters. Each one-cycle overflow pulse sets a sticky pending bit. Software clears that bit by writing a one to an acknowledge register.

An interrupt mask decides which pending bits may raise the line. The mask cannot be written directly. Software sets bits in it by writing ones to an arm register and clears bits by writing ones to a disarm register. A zero in either write leaves the matching bit as it was. A separate read-only view returns the current mask. The output line is a registered OR over the pending bits that are armed.

Top module: `ovf_irq_ctrl`

## Requirements
- R1: While reset is held and in the cycle after it, every mask bit, every pending bit and the `irq` output are zero.
- R2: A write to register select 0 (arm) sets each mask bit whose write-data bit is one. Mask bits whose write-data bit is zero keep their value.
- R3: A write to register select 1 (disarm) clears each mask bit whose write-data bit is one. Mask bits whose write-data bit is zero keep their value.
- R4: Reading register select 2 returns the current 24-bit mask.
- R5: Reading register select 4 returns the pending field. General counter i is at bit 8+i for i = 0..15, and bandwidth counter j is at bit j for j = 0..7.
- R6: An overflow pulse sets its pending bit whether or not that source is armed. The bit then stays set until it is acknowledged.
- R7: A write to register select 3 (acknowledge) clears each pending bit whose write-data bit is one. Writing 0xFFFFFF clears all of them.
- R8: If an overflow pulse and an acknowledge of the same bit fall in the same cycle, the pending bit ends that cycle set.
- R9: `irq` is registered. In each cycle it equals the OR of (pending AND mask) as that value stood in the previous cycle.
- R10: Writes to selects 2, 4, 5, 6 and 7 change neither the mask nor the pending field. Reads of selects 0, 1, 3, 5, 6 and 7 return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| reg_wr | input | 1 | Write strobe for one cycle |
| reg_addr | input | 3 | Register select |
| reg_wdata | input | 24 | Write data |
| reg_rdata | output | 24 | Read data for `reg_addr`, combinational |
| gen_ovf | input | 16 | Overflow pulses from the general counters |
| bw_ovf | input | 8 | Overflow pulses from the bandwidth counters |
| irq | output | 1 | Level interrupt |

## Verification
The key collision is an overflow pulse and an acknowledge write that hit the same pending bit in the same clock. The bench drives a bandwidth-counter pulse together with an acknowledge of that bit. It then expects the bit to read back as set and the line to rise one cycle later. A random phase then mixes frequent pulses with arm, disarm and acknowledge writes, so the same cycle often carries both a set and a clear. In that phase a behavioural reference model is compared against the read data and the interrupt on every clock.

// File: rtl/ovf_irq_pkg.sv
package ovf_irq_pkg;

    localparam int GEN_CNT = 16;
    localparam int BW_CNT  = 8;
    localparam int SRC_W   = GEN_CNT + BW_CNT;
    localparam int SEL_W   = 3;

    typedef logic [SRC_W-1:0] src_vec_t;

    typedef enum logic [SEL_W-1:0] {
        SEL_ARM    = 3'd0,
        SEL_DISARM = 3'd1,
        SEL_MASK   = 3'd2,
        SEL_ACK    = 3'd3,
        SEL_PEND   = 3'd4
    } reg_sel_e;

    typedef struct packed {
        src_vec_t arm;
        src_vec_t disarm;
        src_vec_t ack;
    } wr_strobe_t;

    // General counters occupy the upper field, bandwidth counters the lower.
    function automatic src_vec_t pack_sources(input logic [GEN_CNT-1:0] gen,
                                              input logic [BW_CNT-1:0]  bw);
        return {gen, bw};
    endfunction

endpackage

// File: rtl/ovf_irq_decode.sv
module ovf_irq_decode
    import ovf_irq_pkg::*;
(
    input  logic             wr,
    input  logic [SEL_W-1:0] addr,
    input  src_vec_t         wdata,
    input  src_vec_t         mask,
    input  src_vec_t         pend,
    output wr_strobe_t       strobe,
    output src_vec_t         rdata
);

    reg_sel_e sel;
    assign sel = reg_sel_e'(addr);

    always_comb begin
        strobe = '0;
        if (wr) begin
            case (sel)
                SEL_ARM:    strobe.arm    = wdata;
                SEL_DISARM: strobe.disarm = wdata;
                SEL_ACK:    strobe.ack    = wdata;
                default:    strobe        = '0;
            endcase
        end
    end

    always_comb begin
        case (sel)
            SEL_MASK: rdata = mask;
            SEL_PEND: rdata = pend;
            default:  rdata = '0;
        endcase
    end

endmodule

// File: rtl/ovf_irq_mask.sv
module ovf_irq_mask
    import ovf_irq_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  src_vec_t arm,
    input  src_vec_t disarm,
    output src_vec_t mask_q
);

    always_ff @(posedge clk) begin
        if (rst) mask_q <= '0;
        else     mask_q <= (mask_q | arm) & ~disarm;
    end

endmodule

// File: rtl/ovf_irq_pending.sv
module ovf_irq_pending
    import ovf_irq_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  src_vec_t src,
    input  src_vec_t ack,
    output src_vec_t pend_q
);

    for (genvar i = 0; i < SRC_W; i++) begin : g_bit
        logic bit_q;
        always_ff @(posedge clk) begin
            if (rst)         bit_q <= 1'b0;
            else if (src[i]) bit_q <= 1'b1;
            else if (ack[i]) bit_q <= 1'b0;
        end
        assign pend_q[i] = bit_q;
    end

endmodule

// File: rtl/ovf_irq_ctrl.sv
module ovf_irq_ctrl
    import ovf_irq_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               reg_wr,
    input  logic [SEL_W-1:0]   reg_addr,
    input  logic [SRC_W-1:0]   reg_wdata,
    output logic [SRC_W-1:0]   reg_rdata,
    input  logic [GEN_CNT-1:0] gen_ovf,
    input  logic [BW_CNT-1:0]  bw_ovf,
    output logic               irq
);

    wr_strobe_t strobe;
    src_vec_t   en_mask;
    src_vec_t   pend_bits;
    src_vec_t   sources;

    assign sources = pack_sources(gen_ovf, bw_ovf);

    ovf_irq_decode u_decode (
        .wr     (reg_wr),
        .addr   (reg_addr),
        .wdata  (reg_wdata),
        .mask   (en_mask),
        .pend   (pend_bits),
        .strobe (strobe),
        .rdata  (reg_rdata)
    );

    ovf_irq_mask u_mask (
        .clk    (clk),
        .rst    (rst),
        .arm    (strobe.arm),
        .disarm (strobe.disarm),
        .mask_q (en_mask)
    );

    ovf_irq_pending u_pend (
        .clk    (clk),
        .rst    (rst),
        .src    (sources),
        .ack    (strobe.ack),
        .pend_q (pend_bits)
    );

    always_ff @(posedge clk) begin
        if (rst) irq <= 1'b0;
        else     irq <= |(pend_bits & en_mask);
    end

endmodule

// File: rtl/ovf_irq_ctrl_chk.sv
module ovf_irq_ctrl_chk
    import ovf_irq_pkg::*;
(
    input logic               clk,
    input logic               rst,
    input logic               reg_wr,
    input logic [SEL_W-1:0]   reg_addr,
    input logic [SRC_W-1:0]   reg_wdata,
    input logic [GEN_CNT-1:0] gen_ovf,
    input logic [BW_CNT-1:0]  bw_ovf,
    input logic [SRC_W-1:0]   en_q,
    input logic [SRC_W-1:0]   pend_q,
    input logic               irq
);

    logic [SRC_W-1:0] src_w, ack_w;
    logic arm_wr, disarm_wr;
    logic armed, rst_d;

    assign src_w     = {gen_ovf, bw_ovf};
    assign ack_w     = (reg_wr && reg_addr == SEL_ACK) ? reg_wdata : '0;
    assign arm_wr    = reg_wr && reg_addr == SEL_ARM;
    assign disarm_wr = reg_wr && reg_addr == SEL_DISARM;

    always_ff @(posedge clk) begin
        armed <= !rst;
        rst_d <= rst;
        if (rst_d) begin
            assert_reset_clear_R1: assert (en_q == '0 && pend_q == '0 && !irq);
        end
    end

    assert_arm_sets_R2: assert property (@(posedge clk) disable iff (rst)
        arm_wr |=> ((en_q & $past(reg_wdata)) == $past(reg_wdata)));

    assert_disarm_clears_R3: assert property (@(posedge clk) disable iff (rst)
        disarm_wr |=> ((en_q & $past(reg_wdata)) == '0));

    assert_mask_hold_R10: assert property (@(posedge clk) disable iff (rst)
        !(arm_wr || disarm_wr) |=> $stable(en_q));

    assert_sticky_R6: assert property (@(posedge clk) disable iff (rst)
        armed |-> ((($past(pend_q) & ~$past(ack_w)) & ~pend_q) == '0));

    assert_pulse_wins_R8: assert property (@(posedge clk) disable iff (rst)
        (src_w != '0) |=> ((pend_q & $past(src_w)) == $past(src_w)));

    assert_irq_lag_R9: assert property (@(posedge clk) disable iff (rst)
        armed |-> (irq == $past(|(pend_q & en_q))));

endmodule

bind ovf_irq_ctrl ovf_irq_ctrl_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .reg_wr    (reg_wr),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .gen_ovf   (gen_ovf),
    .bw_ovf    (bw_ovf),
    .en_q      (en_mask),
    .pend_q    (pend_bits),
    .irq       (irq)
);

// File: tb/ovf_irq_ctrl_tb.sv
module ovf_irq_ctrl_tb;

    localparam int CLK_P = 10;

    logic        clk = 1'b0;
    logic        rst;
    logic        reg_wr;
    logic [2:0]  reg_addr;
    logic [23:0] reg_wdata;
    logic [23:0] reg_rdata;
    logic [15:0] gen_ovf;
    logic [7:0]  bw_ovf;
    logic        irq;

    int total = 0;
    int bad   = 0;
    bit live  = 0;
    bit done  = 0;

    logic [23:0] m_en, m_st;
    logic        m_irq;

    always #(CLK_P/2) clk = ~clk;

    ovf_irq_ctrl u_dut (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .gen_ovf(gen_ovf), .bw_ovf(bw_ovf), .irq(irq)
    );

    task automatic check(input bit ok, input string req, input logic [23:0] act,
                         input logic [23:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%06h expected=%06h", req, act, exp);
        end
    endtask

    // Behavioural reference, updated on each rising edge.
    always @(posedge clk) begin
        if (rst) begin
            m_en <= '0; m_st <= '0; m_irq <= 1'b0;
        end else begin
            m_irq <= (m_st & m_en) != 0;
            if (reg_wr && reg_addr == 3'd0)      m_en <= m_en | reg_wdata;
            else if (reg_wr && reg_addr == 3'd1) m_en <= m_en & ~reg_wdata;
            m_st <= (m_st & ~((reg_wr && reg_addr == 3'd3) ? reg_wdata : 24'h0))
                    | {gen_ovf, bw_ovf};
        end
    end

    // Per-clock comparison, a quarter period after the edge.
    always @(posedge clk) begin
        #(CLK_P/4);
        if (live && !rst) begin
            logic [23:0] exp_rd;
            exp_rd = (reg_addr == 3'd2) ? m_en : (reg_addr == 3'd4) ? m_st : 24'h0;
            check(irq == m_irq, "R9 model irq", {23'h0, irq}, {23'h0, m_irq});
            check(reg_rdata == exp_rd,
                  reg_addr == 3'd2 ? "R4 model mask" :
                  reg_addr == 3'd4 ? "R5 model pend" : "R10 model zero-read",
                  reg_rdata, exp_rd);
        end
    end

    task automatic do_write(input logic [2:0] a, input logic [23:0] d);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0; reg_wdata = '0;
    endtask

    task automatic pulse(input logic [15:0] g, input logic [7:0] b);
        gen_ovf = g; bw_ovf = b;
        @(negedge clk);
        gen_ovf = '0; bw_ovf = '0;
    endtask

    task automatic read_chk(input logic [2:0] a, input logic [23:0] exp, input string req);
        reg_addr = a;
        #1;
        check(reg_rdata == exp, req, reg_rdata, exp);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; reg_wr = 1'b0; reg_addr = '0; reg_wdata = '0;
        gen_ovf = '0; bw_ovf = '0;
        repeat (3) @(negedge clk);
        read_chk(3'd2, 24'h0, "R1 mask after reset");
        read_chk(3'd4, 24'h0, "R1 pend after reset");
        check(irq == 1'b0, "R1 irq after reset", {23'h0, irq}, 24'h0);
        rst = 1'b0;
        live = 1;

        do_write(3'd0, 24'h000F01);
        read_chk(3'd2, 24'h000F01, "R2 arm");
        do_write(3'd0, 24'h100000);
        read_chk(3'd2, 24'h100F01, "R2 zeros keep");
        do_write(3'd1, 24'h000100);
        read_chk(3'd2, 24'h100E01, "R3 disarm");

        // gen counter 3 -> bit 11 (armed), bw counter 5 -> bit 5 (not armed)
        pulse(16'h0008, 8'h20);
        read_chk(3'd4, 24'h000820, "R5 layout / R6 unarmed sets");
        check(irq == 1'b0, "R9 irq lags one cycle", {23'h0, irq}, 24'h0);
        @(negedge clk);
        check(irq == 1'b1, "R9 irq raised", {23'h0, irq}, 24'h1);
        repeat (4) @(negedge clk);
        read_chk(3'd4, 24'h000820, "R6 sticky");

        do_write(3'd3, 24'h000800);
        read_chk(3'd4, 24'h000020, "R7 ack one bit");
        @(negedge clk);
        check(irq == 1'b0, "R9 unarmed pending no irq", {23'h0, irq}, 24'h0);

        // Pulse and acknowledge of bit 0 in the same cycle.
        gen_ovf = '0; bw_ovf = 8'h01;
        do_write(3'd3, 24'h000001);
        bw_ovf = '0;
        read_chk(3'd4, 24'h000021, "R8 pulse beats ack");
        @(negedge clk);
        check(irq == 1'b1, "R8 irq after collision", {23'h0, irq}, 24'h1);

        do_write(3'd4, 24'h000000);
        do_write(3'd2, 24'hFFFFFF);
        do_write(3'd7, 24'hFFFFFF);
        read_chk(3'd2, 24'h100E01, "R10 mask untouched");
        read_chk(3'd4, 24'h000021, "R10 pend untouched");
        do_write(3'd0, 24'h000000);
        read_chk(3'd0, 24'h0, "R10 arm reads zero");
        read_chk(3'd3, 24'h0, "R10 ack reads zero");

        do_write(3'd3, 24'hFFFFFF);
        read_chk(3'd4, 24'h0, "R7 clear all");
        @(negedge clk);
        check(irq == 1'b0, "R9 irq drops", {23'h0, irq}, 24'h0);

        pulse(16'h8000, 8'h00);
        read_chk(3'd4, 24'h800000, "R5 general 15 at bit 23");
        pulse(16'h0001, 8'h00);
        read_chk(3'd4, 24'h800100, "R5 general 0 at bit 8");
        pulse(16'h0000, 8'h80);
        read_chk(3'd4, 24'h800180, "R5 bandwidth 7 at bit 7");

        for (int n = 0; n < 600; n++) begin
            reg_wr    = ($urandom_range(0, 2) == 0);
            reg_addr  = 3'($urandom_range(0, 7));
            reg_wdata = 24'($urandom) & 24'($urandom);
            gen_ovf   = ($urandom_range(0, 3) == 0) ? 16'(1 << $urandom_range(0, 15)) : 16'h0;
            bw_ovf    = ($urandom_range(0, 3) == 0) ? 8'(1 << $urandom_range(0, 7)) : 8'h0;
            @(negedge clk);
        end
        reg_wr = 1'b0; gen_ovf = '0; bw_ovf = '0;

        rst = 1'b1;
        @(negedge clk);
        live = 0;
        read_chk(3'd2, 24'h0, "R1 mask after late reset");
        read_chk(3'd4, 24'h0, "R1 pend after late reset");
        check(irq == 1'b0, "R1 irq after late reset", {23'h0, irq}, 24'h0);

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule